// File: doc/BRIEF.md
# Program Counter and Interrupt Sequencer

This block keeps the program counter of a small byte-fetching controller, together with two single-entry save registers: one for subroutine linkage and one for interrupt linkage. An external decoder drives it through strobes. A fetch strobe steps the counter by one byte and raises the program gate. An operation strobe with a 3-bit code selects the control-flow change. An end-of-execute strobe is the one moment at which the active-low interrupt request is looked at.

When the request is low at that moment, the block spends the next clock in a vector cycle. During that cycle the acknowledge output is high, the program gate is low, and every fetch and operation strobe is ignored. At the end of the cycle the current counter moves into the interrupt save register. The counter is then loaded with the data-bus byte in its low bits and zeros above. There is no enable input: masking, if wanted, is done outside the block. A subroutine return exchanges the return address with the save register, so a pair of returns ping-pongs between two places.

Top module: `pcseq_core`

## Requirements
- R1: Reset (rst_n low) clears the counter, both save registers, the instruction-start address and the vector state, so prog_addr and int_ack read 0.
- R2: In a cycle with fetch_en high and no vector cycle, prog_gate is high, prog_addr shows the counter, and the counter advances by one at the next edge (modulo 2048) unless an operation strobe overrides it.
- R3: fetch_en together with instr_start records the current counter as the address of the instruction's first byte, which is used for the "plus 2" saves.
- R4: op_valid with op_code 0 (skip) adds 2 to the counter when skip_hit is 1 (wrapping modulo 2048) and leaves it unchanged when skip_hit is 0.
- R5: op_code 1 (jump) loads the counter from jump_target.
- R6: op_code 2 (jump to subroutine) loads the counter from jump_target and writes the recorded first-byte address plus 2 into the subroutine save register.
- R7: op_code 5 (subroutine return) loads the counter from the subroutine save register and, in the same edge, writes the recorded first-byte address plus 2 into that register.
- R8: op_code 3 (indirect jump) loads the counter with {page_z OR page_r0, acc}. op_code 4 does the same and also saves the first-byte address plus 2 in the subroutine save register.
- R9: exec_done high while irq_n is low raises int_ack in the following cycle. irq_n low without exec_done, or exec_done with irq_n high, raises nothing.
- R10: int_ack stays high for exactly one clock per interrupt.
- R11: At the end of the acknowledge cycle the counter is copied into the interrupt save register and the counter becomes {3'b000, data_in}.
- R12: During the acknowledge cycle prog_gate is low and fetch_en and op_valid have no effect on the counter.
- R13: op_code 6 (interrupt return) loads the counter from the interrupt save register. op_code 7 is reserved and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_en | input | 1 | Fetch one program byte at the counter |
| instr_start | input | 1 | Marks the fetch as an instruction's first byte |
| op_valid | input | 1 | Apply the control-flow operation in op_code |
| op_code | input | 3 | 0 skip, 1 jump, 2 jump-sub, 3 indirect, 4 indirect-sub, 5 sub return, 6 int return, 7 reserved |
| skip_hit | input | 1 | Skip condition is true |
| jump_target | input | 11 | Direct jump address |
| acc | input | 8 | Offset for indirect jumps |
| page_z | input | 3 | Page bits from the instruction |
| page_r0 | input | 3 | Page bits from the index register |
| exec_done | input | 1 | End of an instruction's execute phase |
| irq_n | input | 1 | Active-low interrupt request |
| data_in | input | 8 | Data bus, read as the vector |
| prog_addr | output | 11 | Program address (the counter) |
| prog_gate | output | 1 | Program byte fetch in progress |
| int_ack | output | 1 | Vector fetch acknowledge |

## Verification
The bench issues two subroutine returns in a row. A design that only restores the counter, without writing the return address back, would land at a stale address on the second return. It performs a skip from address 2047 to check the wrap to 1; a counter that saturated, or that carried into a wider register, would miss this. During the acknowledge cycle it also asserts fetch and a jump. A design that let those strobes through would lose the vector, or save the wrong address for the interrupt return. It further checks that a low request without the end-of-execute strobe is never taken, and that a mid-run reset empties both save registers.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
   typedef enum logic [2:0] {
      OP_SKIP    = 3'd0,
      OP_JUMP    = 3'd1,
      OP_JSUB    = 3'd2,
      OP_IND     = 3'd3,
      OP_IND_SUB = 3'd4,
      OP_SRET    = 3'd5,
      OP_IRET    = 3'd6,
      OP_RSVD    = 3'd7
   } pcseq_op_e;
endpackage

// File: rtl/pcseq_savereg.sv
module pcseq_savereg #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
   end
endmodule

// File: rtl/pcseq_vector.sv
module pcseq_vector (
   input  logic clk,
   input  logic rst_n,
   input  logic exec_done,
   input  logic irq_n,
   output logic vec_active
);
   always_ff @(posedge clk) begin
      if (!rst_n) vec_active <= 1'b0;
      else        vec_active <= !vec_active && exec_done && !irq_n;
   end
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
   import pcseq_pkg::*;
#(
   parameter int PC_W   = 11,
   parameter int DATA_W = 8,
   parameter int SKIP_B = 2
) (
   input  logic [PC_W-1:0]        pc,
   input  logic [PC_W-1:0]        start_addr,
   input  logic [PC_W-1:0]        ssr,
   input  logic [PC_W-1:0]        isr,
   input  logic                   fetch_en,
   input  logic                   op_valid,
   input  logic [2:0]             op_code,
   input  logic                   skip_hit,
   input  logic [PC_W-1:0]        jump_target,
   input  logic [DATA_W-1:0]      acc,
   input  logic [PC_W-DATA_W-1:0] page_z,
   input  logic [PC_W-DATA_W-1:0] page_r0,
   output logic [PC_W-1:0]        pc_next,
   output logic                   pc_load,
   output logic [PC_W-1:0]        ssr_next,
   output logic                   ssr_load
);
   localparam int PAGE_W = PC_W - DATA_W;

   pcseq_op_e               op;
   logic [PC_W-1:0]         ind_addr;
   logic [PC_W-1:0]         link_addr;

   assign op        = pcseq_op_e'(op_code);
   assign ind_addr  = {page_z | page_r0, acc};
   assign link_addr = start_addr + PC_W'(SKIP_B);
   assign ssr_next  = link_addr;

   always_comb begin
      pc_next  = pc + PC_W'(1);
      pc_load  = fetch_en;
      ssr_load = 1'b0;
      if (op_valid) begin
         pc_load = 1'b1;
         unique case (op)
            OP_SKIP: begin
               pc_next = pc + PC_W'(SKIP_B);
               pc_load = skip_hit;
            end
            OP_JUMP: pc_next = jump_target;
            OP_JSUB: begin
               pc_next  = jump_target;
               ssr_load = 1'b1;
            end
            OP_IND:  pc_next = ind_addr;
            OP_IND_SUB: begin
               pc_next  = ind_addr;
               ssr_load = 1'b1;
            end
            OP_SRET: begin
               pc_next  = ssr;
               ssr_load = 1'b1;
            end
            OP_IRET: pc_next = isr;
            OP_RSVD: pc_load = 1'b0;
         endcase
      end
   end

   logic [PAGE_W-1:0] unused_w;
   assign unused_w = '0;
endmodule

// File: rtl/pcseq_core.sv
module pcseq_core #(
   parameter int PC_W   = 11,
   parameter int DATA_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fetch_en,
   input  logic                   instr_start,
   input  logic                   op_valid,
   input  logic [2:0]             op_code,
   input  logic                   skip_hit,
   input  logic [PC_W-1:0]        jump_target,
   input  logic [DATA_W-1:0]      acc,
   input  logic [PC_W-DATA_W-1:0] page_z,
   input  logic [PC_W-DATA_W-1:0] page_r0,
   input  logic                   exec_done,
   input  logic                   irq_n,
   input  logic [DATA_W-1:0]      data_in,
   output logic [PC_W-1:0]        prog_addr,
   output logic                   prog_gate,
   output logic                   int_ack
);
   localparam int PAGE_W = PC_W - DATA_W;

   generate
      if (PC_W <= DATA_W) begin : g_bad_width
         $error("pcseq_core: PC_W must exceed DATA_W");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("pcseq_core: DATA_W must be positive");
      end
   endgenerate

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_next;
   logic            pc_load;
   logic [PC_W-1:0] ssr_q;
   logic [PC_W-1:0] ssr_next;
   logic            ssr_load;
   logic [PC_W-1:0] isr_q;
   logic [PC_W-1:0] start_q;
   logic            vec_active;

   pcseq_vector i_vector (
      .clk        (clk),
      .rst_n      (rst_n),
      .exec_done  (exec_done),
      .irq_n      (irq_n),
      .vec_active (vec_active)
   );

   pcseq_target #(.PC_W(PC_W), .DATA_W(DATA_W), .SKIP_B(2)) i_target (
      .pc          (pc_q),
      .start_addr  (start_q),
      .ssr         (ssr_q),
      .isr         (isr_q),
      .fetch_en    (fetch_en),
      .op_valid    (op_valid),
      .op_code     (op_code),
      .skip_hit    (skip_hit),
      .jump_target (jump_target),
      .acc         (acc),
      .page_z      (page_z),
      .page_r0     (page_r0),
      .pc_next     (pc_next),
      .pc_load     (pc_load),
      .ssr_next    (ssr_next),
      .ssr_load    (ssr_load)
   );

   pcseq_savereg #(.W(PC_W)) i_start (
      .clk (clk), .rst_n (rst_n),
      .load (fetch_en && instr_start && !vec_active),
      .din (pc_q), .q (start_q)
   );

   pcseq_savereg #(.W(PC_W)) i_ssr (
      .clk (clk), .rst_n (rst_n),
      .load (ssr_load && !vec_active),
      .din (ssr_next), .q (ssr_q)
   );

   pcseq_savereg #(.W(PC_W)) i_isr (
      .clk (clk), .rst_n (rst_n),
      .load (vec_active),
      .din (pc_q), .q (isr_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          pc_q <= '0;
      else if (vec_active) pc_q <= {{PAGE_W{1'b0}}, data_in};
      else if (pc_load)    pc_q <= pc_next;
   end

   assign prog_addr = pc_q;
   assign prog_gate = fetch_en && !vec_active;
   assign int_ack   = vec_active;
endmodule

// File: rtl/pcseq_core_chk.sv
module pcseq_core_chk #(
   parameter int PC_W   = 11,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_en,
   input logic              op_valid,
   input logic              exec_done,
   input logic              irq_n,
   input logic [DATA_W-1:0] data_in,
   input logic [PC_W-1:0]   prog_addr,
   input logic              prog_gate,
   input logic              int_ack
);
   localparam int PAGE_W = PC_W - DATA_W;

   AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |-> $past(exec_done && !irq_n)); // R9
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |=> !int_ack); // R10
   AST_VECTOR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |=> prog_addr == {{PAGE_W{1'b0}}, $past(data_in)}); // R11
   AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |-> !prog_gate); // R12
   AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_gate && !op_valid) |=> prog_addr == $past(prog_addr) + PC_W'(1)); // R2
   AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_en && !op_valid && !int_ack) |=> $stable(prog_addr)); // R13
endmodule

bind pcseq_core pcseq_core_chk #(.PC_W(PC_W), .DATA_W(DATA_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fetch_en  (fetch_en),
   .op_valid  (op_valid),
   .exec_done (exec_done),
   .irq_n     (irq_n),
   .data_in   (data_in),
   .prog_addr (prog_addr),
   .prog_gate (prog_gate),
   .int_ack   (int_ack)
);

// File: tb/test_pcseq_core.sv
`timescale 1ns/1ps
module test_pcseq_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_en = 1'b0;
   logic        instr_start = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = 3'd0;
   logic        skip_hit = 1'b0;
   logic [10:0] jump_target = '0;
   logic [7:0]  acc = '0;
   logic [2:0]  page_z = '0;
   logic [2:0]  page_r0 = '0;
   logic        exec_done = 1'b0;
   logic        irq_n = 1'b1;
   logic [7:0]  data_in = '0;
   logic [10:0] prog_addr;
   logic        prog_gate;
   logic        int_ack;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pcseq_core i_pcseq_core (.*);

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      fetch_en = 0; instr_start = 0; op_valid = 0; skip_hit = 0;
      exec_done = 0; irq_n = 1;
   endtask

   task automatic fetch(bit start);
      fetch_en = 1; instr_start = start;
      #0.5 chk("R2 gate during fetch", prog_gate, 1);
      tick();
      idle();
   endtask

   task automatic op(logic [2:0] code);
      op_valid = 1; op_code = code;
      tick();
      idle();
   endtask

   task automatic t_reset();
      chk("R1 reset addr", prog_addr, 0);
      chk("R1 reset ack", int_ack, 0);
      chk("R1 reset gate", prog_gate, 0);
   endtask

   task automatic t_fetch();
      fetch(1); chk("R2 step", prog_addr, 1);
      fetch(0); fetch(0); chk("R2 three bytes", prog_addr, 3);
   endtask

   task automatic t_skip();
      skip_hit = 1; op_valid = 1; op_code = 3'd0; tick(); idle();
      chk("R4 skip taken", prog_addr, 5);
      skip_hit = 0; op_valid = 1; op_code = 3'd0; tick(); idle();
      chk("R4 skip not taken", prog_addr, 5);
   endtask

   task automatic t_sub();
      jump_target = 11'h123; op(3'd1);
      chk("R5 jump", prog_addr, 11'h123);
      fetch(1); fetch(0);
      jump_target = 11'h400; op(3'd2);
      chk("R6 jsub target", prog_addr, 11'h400);
      fetch(1); op(3'd5);
      chk("R7 first return", prog_addr, 11'h125);
      fetch(1); op(3'd5);
      chk("R7 swapped return R3", prog_addr, 11'h402);
   endtask

   task automatic t_indirect();
      page_z = 3'b100; page_r0 = 3'b001; acc = 8'h5A; op(3'd3);
      chk("R8 indirect", prog_addr, 11'h55A);
      fetch(1);
      page_z = 3'b000; page_r0 = 3'b010; acc = 8'h10; op(3'd4);
      chk("R8 indirect sub", prog_addr, 11'h210);
      op(3'd5);
      chk("R8 indirect sub link", prog_addr, 11'h55C);
      op(3'd7);
      chk("R13 reserved op", prog_addr, 11'h55C);
   endtask

   task automatic t_irq();
      exec_done = 1; irq_n = 1; tick(); idle();
      chk("R9 no request", int_ack, 0);
      exec_done = 0; irq_n = 0; tick(); idle();
      chk("R9 request without exec_done", int_ack, 0);
      chk("R9 pc untouched", prog_addr, 11'h55C);
      exec_done = 1; irq_n = 0; tick(); idle();
      chk("R9 ack raised", int_ack, 1);
      fetch_en = 1; op_valid = 1; op_code = 3'd1; jump_target = 11'h7FF;
      data_in = 8'hC3;
      #0.5 chk("R12 gate low in vector", prog_gate, 0);
      tick(); idle();
      chk("R10 ack one clock", int_ack, 0);
      chk("R11 vector load R12", prog_addr, 11'h0C3);
      op(3'd6);
      chk("R13 interrupt return R11", prog_addr, 11'h55C);
   endtask

   task automatic t_wrap();
      jump_target = 11'h7FF; op(3'd1);
      skip_hit = 1; op_valid = 1; op_code = 3'd0; tick(); idle();
      chk("R4 skip wraps", prog_addr, 11'h001);
   endtask

   task automatic t_midreset();
      jump_target = 11'h300; op(3'd2);
      rst_n = 0; tick(); rst_n = 1;
      chk("R1 reset mid-run", prog_addr, 0);
      jump_target = 11'h050; op(3'd1);
      op(3'd6);
      chk("R1 interrupt save cleared", prog_addr, 0);
      jump_target = 11'h050; op(3'd1);
      op(3'd5);
      chk("R1 subroutine save cleared", prog_addr, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      tick();
      t_reset();
      t_fetch();
      t_skip();
      t_sub();
      t_indirect();
      t_irq();
      t_wrap();
      t_midreset();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule